// File: doc/BRIEF.md
# Serial Memory Read Port with Streaming Readout

This block is the slave side of a three-wire serial memory link: a chip select, a serial clock and a serial data input, plus one data output that can be released. It holds a small register array of either 64 sixteen-bit words or 128 eight-bit words. The host raises chip select and shifts a command frame in on the data input: a start bit, a two-bit opcode and an address. For the read opcode the block enables its output and sends one zero bit. It then sends the addressed word, most significant bit first, one bit per serial clock rise. While chip select stays high it carries on with the following addresses, wrapping from the last address to address 0, with no gap bit between words.

The serial pins are sampled in the system clock domain through a short synchronizer, and rising edges of the serial clock are found there. The output is given as a data bit plus an enable; the pad outside turns these into a tri-state pin. Writing and erasing the array belong to a neighbouring block, which loads words through a plain synchronous write port. The array comes out of reset in the erased state, all ones.

Top module: `mwr_read_port`

## Requirements
- R1: While chip select is high and no frame is open, data input values of 0 sampled on serial clock rises are skipped; the first 1 sampled opens a frame.
- R2: After the start bit, two opcode bits are taken (binary 10 selects read), then the address bits, most significant first (6 bits for 16-bit words, 7 bits for 8-bit words). The output enable stays low until the rise that samples the last address bit. After that rise it goes high and the output carries a 0 (dummy) bit.
- R3: On each following serial clock rise the output moves to the next bit of the addressed word, most significant bit first.
- R4: The output bit changes only in response to a serial clock rise. Between rises it holds its value.
- R5: After the least significant bit of a word, the next rise presents the most significant bit of the word at the next address, with no dummy bit in between.
- R6: The streaming address wraps from the top address (63 for 16-bit words) to address 0 and streaming continues.
- R7: A frame whose opcode is 00, 01 or 11 never enables the output. Further serial clocks are skipped until chip select falls.
- R8: Chip select low aborts any frame at any point. The output enable is low within 4 system clocks and stays low while chip select is low. The next frame is decoded from the start-bit search.
- R9: Every array word reads as all ones after reset. A write-port pulse stores the write data at the write address, and later reads return it.
- R10: The parameter WIDE_WORDS set to 1 (the default) gives 16-bit words with a 6-bit address. Set to 0 it gives 8-bit words with a 7-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial command and address input |
| do_data | output | 1 | Serial output bit |
| do_oe | output | 1 | Output enable for the serial output pad |
| mem_we | input | 1 | Array write strobe from the write/erase block |
| mem_waddr | input | 6 or 7 | Array write address |
| mem_wdata | input | 16 or 8 | Array write data |

## Verification
The assertions take for granted that the host changes serial clock and data slowly compared with the system clock. Each serial clock level must last longer than the synchronizer delay so that every rise is seen once, and the data input must be settled by the time the matching rise leaves the synchronizer. They also take for granted that chip select held low is seen as an abort, however briefly the host drops it. The stimulus meets these conditions by keeping each serial clock phase four system clocks long. It changes the data input together with the clock rise, which passes through the same synchronizer depth. It keeps chip select low for several system clocks between frames.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  // Decoder phases for one command frame.
  typedef enum logic [2:0] {
    ST_HUNT   = 3'd0,  // waiting for the start bit
    ST_OP_HI  = 3'd1,  // first opcode bit expected
    ST_OP_LO  = 3'd2,  // second opcode bit expected
    ST_ADDR   = 3'd3,  // address bits arriving
    ST_STREAM = 3'd4,  // read data leaving on the output
    ST_SKIP   = 3'd5   // non-read frame, wait for deselect
  } mwr_state_e;

  localparam logic [1:0] OPC_READ = 2'b10;

  // Word size follows the organisation choice.
  function automatic int word_width(input bit wide);
    return wide ? 16 : 8;
  endfunction

  // Address size keeps the array at 1024 bits either way.
  function automatic int addr_width(input bit wide);
    return wide ? 6 : 7;
  endfunction

endpackage

// File: rtl/mwr_pin_sampler.sv
module mwr_pin_sampler #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise
);

  logic [SYNC_DEPTH-1:0] cs_p;
  logic [SYNC_DEPTH-1:0] sk_p;
  logic [SYNC_DEPTH-1:0] di_p;
  logic                  sk_d;

  generate
    if (SYNC_DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_p <= '0;
          sk_p <= '0;
          di_p <= '0;
        end else begin
          cs_p <= cs;
          sk_p <= sk;
          di_p <= di;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_p <= '0;
          sk_p <= '0;
          di_p <= '0;
        end else begin
          cs_p <= {cs_p[SYNC_DEPTH-2:0], cs};
          sk_p <= {sk_p[SYNC_DEPTH-2:0], sk};
          di_p <= {di_p[SYNC_DEPTH-2:0], di};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_d <= 1'b0;
    else        sk_d <= sk_p[SYNC_DEPTH-1];
  end

  assign cs_s    = cs_p[SYNC_DEPTH-1];
  assign di_s    = di_p[SYNC_DEPTH-1];
  assign sk_rise = sk_p[SYNC_DEPTH-1] & ~sk_d;

endmodule

// File: rtl/mwr_cmd_decoder.sv
module mwr_cmd_decoder
  import mwr_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          di_s,
  input  logic          sk_rise,
  output logic          stream_go,
  output logic [AW-1:0] start_addr,
  output logic          in_skip
);

  localparam int CW = $clog2(AW);
  localparam logic [CW-1:0] LAST_IDX = CW'(AW - 1);

  mwr_state_e    state;
  logic [1:0]    opcode;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_sh;
  logic          addr_last;

  // The rise carrying the final address bit.
  assign addr_last  = cs_s && sk_rise && (state == ST_ADDR) && (cnt == LAST_IDX);
  assign stream_go  = addr_last && (opcode == OPC_READ);
  assign start_addr = {addr_sh[AW-2:0], di_s};
  assign in_skip    = (state == ST_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      opcode  <= 2'b00;
      cnt     <= '0;
      addr_sh <= '0;
    end else if (!cs_s) begin
      state <= ST_HUNT;
      cnt   <= '0;
    end else if (sk_rise) begin
      case (state)
        ST_HUNT: begin
          if (di_s) state <= ST_OP_HI;
        end
        ST_OP_HI: begin
          opcode[1] <= di_s;
          state     <= ST_OP_LO;
        end
        ST_OP_LO: begin
          opcode[0] <= di_s;
          cnt       <= '0;
          state     <= ST_ADDR;
        end
        ST_ADDR: begin
          addr_sh <= {addr_sh[AW-2:0], di_s};
          if (cnt == LAST_IDX) begin
            state <= (opcode == OPC_READ) ? ST_STREAM : ST_SKIP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STREAM: state <= ST_STREAM;
        ST_SKIP:   state <= ST_SKIP;
        default:   state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/mwr_mem_array.sv
module mwr_mem_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Erased state is all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mwr_out_shifter.sv
module mwr_out_shifter #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sk_rise,
  input  logic          stream_go,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] cur_addr,
  output logic [$clog2(DW)-1:0] bit_idx,
  output logic          word_done,
  output logic          do_data,
  output logic          do_oe
);

  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] TOP_BIT = BW'(DW - 1);

  // Address step with natural wrap at the top of the array.
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic shift_now;

  assign shift_now = cs_s && sk_rise && do_oe;
  assign word_done = shift_now && (bit_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      do_oe    <= 1'b0;
      do_data  <= 1'b0;
      bit_idx  <= TOP_BIT;
      cur_addr <= '0;
    end else if (!cs_s) begin
      do_oe <= 1'b0;
    end else if (stream_go) begin
      // Dummy zero leads the first word only.
      do_oe    <= 1'b1;
      do_data  <= 1'b0;
      bit_idx  <= TOP_BIT;
      cur_addr <= start_addr;
    end else if (shift_now) begin
      do_data <= rdata[bit_idx];
      if (bit_idx == '0) begin
        bit_idx  <= TOP_BIT;
        cur_addr <= step_addr(cur_addr);
      end else begin
        bit_idx <= bit_idx - 1'b1;
      end
    end
  end

endmodule

// File: rtl/mwr_read_port.sv
module mwr_read_port
  import mwr_pkg::*;
#(
  parameter bit WIDE_WORDS = 1'b1,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_data,
  output logic do_oe,
  input  logic mem_we,
  input  logic [addr_width(WIDE_WORDS)-1:0] mem_waddr,
  input  logic [word_width(WIDE_WORDS)-1:0] mem_wdata
);

  localparam int DW = word_width(WIDE_WORDS);
  localparam int AW = addr_width(WIDE_WORDS);
  localparam int BW = $clog2(DW);

  // Named internal events, also seen by the bound checker.
  logic          cs_s;
  logic          di_s;
  logic          sk_rise;
  logic          stream_go;
  logic          in_skip;
  logic          word_done;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] rdata;

  mwr_pin_sampler #(.SYNC_DEPTH(SYNC_DEPTH)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .sk      (sk),
    .di      (di),
    .cs_s    (cs_s),
    .di_s    (di_s),
    .sk_rise (sk_rise)
  );

  mwr_cmd_decoder #(.AW(AW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .di_s       (di_s),
    .sk_rise    (sk_rise),
    .stream_go  (stream_go),
    .start_addr (start_addr),
    .in_skip    (in_skip)
  );

  mwr_mem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (cur_addr),
    .rdata (rdata)
  );

  mwr_out_shifter #(.AW(AW), .DW(DW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .sk_rise    (sk_rise),
    .stream_go  (stream_go),
    .start_addr (start_addr),
    .rdata      (rdata),
    .cur_addr   (cur_addr),
    .bit_idx    (bit_idx),
    .word_done  (word_done),
    .do_data    (do_data),
    .do_oe      (do_oe)
  );

endmodule

// File: rtl/mwr_read_port_chk.sv
module mwr_read_port_chk #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_s,
  input logic                  sk_rise,
  input logic                  stream_go,
  input logic                  word_done,
  input logic                  in_skip,
  input logic [AW-1:0]         cur_addr,
  input logic [$clog2(DW)-1:0] bit_idx,
  input logic                  do_data,
  input logic                  do_oe
);

  localparam logic [AW-1:0] ADDR_TOP = '1;

  // R2
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe) |-> !do_data);

  // R2
  oe_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe) |-> $past(stream_go));

  // R3
  bit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && sk_rise && do_oe && !stream_go && bit_idx != '0) |=>
      (bit_idx == $past(bit_idx) - 1'b1));

  // R4
  do_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sk_rise) |-> $stable(do_data));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && cur_addr != ADDR_TOP) |=> (cur_addr == $past(cur_addr) + 1'b1));

  // R6
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && cur_addr == ADDR_TOP) |=> (cur_addr == '0));

  // R7
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !do_oe);

  // R8
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_s) |-> !do_oe);

endmodule

bind mwr_read_port mwr_read_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_s      (cs_s),
  .sk_rise   (sk_rise),
  .stream_go (stream_go),
  .word_done (word_done),
  .in_skip   (in_skip),
  .cur_addr  (cur_addr),
  .bit_idx   (bit_idx),
  .do_data   (do_data),
  .do_oe     (do_oe)
);

// File: tb/mwr_read_port_tb.sv
`timescale 1ns/1ps
module mwr_read_port_tb;

  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 64;
  localparam int NVEC = 6;
  // {lead zeros[15:12], word count[11:8], start address[7:0]}
  localparam logic [15:0] VECS [NVEC] = '{
    16'h0105, 16'h3200, 16'h1311, 16'h023A, 16'h233E, 16'h023F
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_data, do_oe;
  logic mem_we = 1'b0;
  logic [AW-1:0] mem_waddr = '0;
  logic [DW-1:0] mem_wdata = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  mwr_read_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_data(do_data), .do_oe(do_oe),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 16'h1357) ^ 16'hA5C3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = AW'(a); mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
    model[a] = d;
  endtask

  // One serial clock period; samples at the end of each phase.
  task automatic pulse(input logic v, output logic bh, output logic oh,
                       output logic bl, output logic ol);
    di = v; sk = 1'b1;
    repeat (4) @(negedge clk);
    bh = do_data; oh = do_oe;
    sk = 1'b0;
    repeat (4) @(negedge clk);
    bl = do_data; ol = do_oe;
  endtask

  task automatic send_head(input logic [1:0] op, input int addr, input int lead,
                           output int oe_seen, output logic last_b, output logic last_oe);
    logic bh, oh, bl, ol;
    oe_seen = 0;
    cs = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < lead; i++) begin
      pulse(1'b0, bh, oh, bl, ol);
      if (oh || ol) oe_seen++;
    end
    pulse(1'b1, bh, oh, bl, ol);  if (oh || ol) oe_seen++;
    pulse(op[1], bh, oh, bl, ol); if (oh || ol) oe_seen++;
    pulse(op[0], bh, oh, bl, ol); if (oh || ol) oe_seen++;
    for (int i = AW - 1; i >= 1; i--) begin
      pulse(addr[i], bh, oh, bl, ol);
      if (oh || ol) oe_seen++;
    end
    pulse(addr[0], bh, oh, bl, ol);
    last_b = bh; last_oe = oh;
  endtask

  task automatic deselect();
    cs = 1'b0; di = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 oe after deselect", {31'd0, do_oe}, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_read(input int addr, input int nwords, input int lead);
    int oe_seen, unstable;
    logic lb, loe, bh, oh, bl, ol;
    logic [DW-1:0] w;
    string req;
    unstable = 0;
    send_head(2'b10, addr, lead, oe_seen, lb, loe);
    if (lead > 0) check("R1 oe low through leading zeros", oe_seen, 0);
    else          check("R2 oe low during frame", oe_seen, 0);
    check("R2 dummy bit (oe,data)", {30'd0, loe, lb}, 32'd2);
    for (int k = 0; k < nwords; k++) begin
      w = '0;
      for (int b = 0; b < DW; b++) begin
        pulse(1'b0, bh, oh, bl, ol);
        if (bh !== bl || !oh || !ol) unstable++;
        w = {w[DW-2:0], bh};
      end
      if (addr + k >= DEPTH) req = "R6 wrapped word";
      else if (k > 0)        req = "R5 next word";
      else                   req = "R3 first word";
      check(req, w, model[(addr + k) % DEPTH]);
    end
    check("R4 output held between rises", unstable, 0);
    deselect();
  endtask

  initial begin
    logic lb, loe, bh, oh, bl, ol;
    int oe_seen, quiet;
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (4) @(negedge clk);
    check("R8 reset oe", {31'd0, do_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 word width", $bits(mem_wdata), 16);
    check("R10 address width", $bits(mem_waddr), 6);

    // R9: erased value before any write
    run_read(61, 1, 0);
    for (int a = 0; a < 60; a++) wr(a, pat(a));
    wr(61, 16'h0F1E);
    run_read(61, 1, 0);

    // Vector walk: start address, length, leading zeros.
    for (int v = 0; v < NVEC; v++)
      run_read(int'(VECS[v][7:0]), int'(VECS[v][11:8]), int'(VECS[v][15:12]));

    // R7: each non-read opcode keeps the output released.
    for (int op = 0; op < 4; op++) begin
      if (op == 2) continue;
      send_head(2'(op), 9, 1, oe_seen, lb, loe);
      quiet = oe_seen + int'(loe);
      for (int i = 0; i < 20; i++) begin
        pulse(1'b1, bh, oh, bl, ol);
        if (oh || ol) quiet++;
      end
      check("R7 non-read frame stays quiet", quiet, 0);
      deselect();
    end
    run_read(3, 1, 0);

    // R8: abort in mid-word, then a fresh frame.
    send_head(2'b10, 10, 0, oe_seen, lb, loe);
    for (int i = 0; i < 5; i++) pulse(1'b0, bh, oh, bl, ol);
    deselect();
    run_read(11, 2, 0);

    // R8: abort during the opcode, then a fresh frame.
    cs = 1'b1;
    repeat (3) @(negedge clk);
    pulse(1'b1, bh, oh, bl, ol);
    pulse(1'b1, bh, oh, bl, ol);
    deselect();
    run_read(20, 1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule